// File: doc/BRIEF.md
# Access-Restricting Address Decoder

This block is the user-side address decoder placed next to a bus-slave protocol controller. For each operation it looks up the offset address in a small table of address ranges. Each range marks whether the location is read-only, whether a read of it is destructive (a read-and-clear register or a FIFO), and which of the eight mode codes are allowed there. From that it forms a per-cycle address-check response, OK or Bad Address. The decode uses the controller's current-operation mode and read flag, not its pipelined segment-level copies, because with a fast master those can belong to a different operation.

The response passes through a hold stage that models the controller's response latch. It follows the decode while the strobe-1 phase input is high and keeps its last value once that phase ends. Secondary-address cycles are never flagged. Logical-address cycles to data space are exempt when logical addressing is enabled and the acknowledge is low. The controller itself does not suppress the user read strobe for a bad operation, so this block re-times that strobe through a register. It drops the strobe when the operation is bad and the location's read is destructive.

Top module: `acg_decoder`

## Requirements
- R1: In the first cycle after synchronous reset, `addr_bad` and `usr_rd_out` are both 0.
- R2: With no exemption active, a write (`op_read`=0) to a read-only location using a data-transfer mode code (0, 1, 3, 4 or 5) gives Bad Address (`addr_bad`=1). Reads of the same location are OK. Default read-only ranges: 0x10–0x17 and 0x20–0x23.
- R3: A write to a read-only location using mode code 2, 6 or 7 is OK when the range's mode mask allows that code.
- R4: When `sec_cycle`=1, the response is OK for every address and every mode code, including unmapped addresses.
- R5: When `log_addr_en`=1 and `log_ack`=0, the response is OK, as for a secondary-address cycle. When `log_ack`=1, or when `log_addr_en`=0, this term has no effect.
- R6: A mode code whose bit is 0 in the range's mode mask gives Bad Address (mask bit n is mode code n). By default, range 0x30–0x3F allows only modes 0, 1, 2, 6 and 7 (mask 0xC7).
- R7: An address outside every range gives Bad Address for every mode code unless R4 or R5 exempts the cycle. Range 0x00–0x0F is read/write with all modes allowed, so every operation there is OK.
- R8: While `stb1_phase`=1, `addr_bad` takes the decode of the inputs at each rising clock edge. While `stb1_phase`=0 it holds, and input changes have no effect on it.
- R9: `usr_rd_out` is `usr_rd_in` delayed by one clock. It is forced to 0 when the effective response is Bad and the location is destructive (default 0x20–0x23). A bad access to a non-destructive location is not suppressed. The effective response is the live decode while `stb1_phase`=1 and the held values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb1_phase | input | 1 | High during strobe 1; the response hold stage is transparent |
| op_mode | input | 3 | Current-operation mode code |
| op_read | input | 1 | Current-operation read flag (1 = read) |
| off_addr | input | AW | Offset address |
| sec_cycle | input | 1 | Secondary-address cycle indication |
| log_addr_en | input | 1 | Logical addressing enabled |
| log_ack | input | 1 | Logical-addressing acknowledge |
| usr_rd_in | input | 1 | User read strobe from the controller |
| addr_bad | output | 1 | Held address-check response (1 = Bad Address) |
| usr_rd_out | output | 1 | Gated, registered user read strobe |

## Verification
Both results arrive one clock after the stimulus. `addr_bad` reflects the operation presented at the first rising edge with `stb1_phase` high. `usr_rd_out` reflects `usr_rd_in` and the effective response at that same edge. Each scenario task drives its inputs on a falling edge and checks both outputs on the following falling edge, so exactly one register lies between stimulus and sample. Hold behaviour is checked over several further falling edges after the strobe-1 phase drops, with the address and mode changed in between.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int MODE_W = 3;
  localparam int NMODES = 1 << MODE_W;

  typedef struct packed {
    logic              hit;
    logic              ro;
    logic              destr;
    logic [NMODES-1:0] allow;
  } acg_region_t;
endpackage

// File: rtl/acg_region_lookup.sv
module acg_region_lookup
  import acg_pkg::*;
#(
  parameter int                     AW    = 8,
  parameter int                     NREG  = 4,
  parameter logic [NREG*AW-1:0]     BASE  = '0,
  parameter logic [NREG*AW-1:0]     LAST  = '0,
  parameter logic [NREG-1:0]        RO    = '0,
  parameter logic [NREG-1:0]        DESTR = '0,
  parameter logic [NREG*NMODES-1:0] MASKS = '0
) (
  input  logic [AW-1:0] addr,
  output acg_region_t   region
);
  logic [NREG-1:0] match;

  // one comparator pair per range
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    localparam logic [AW-1:0] LO = BASE[g*AW +: AW];
    localparam logic [AW-1:0] HI = LAST[g*AW +: AW];
    assign match[g] = (addr >= LO) && (addr <= HI);
  end

  // lowest index wins on overlap
  always_comb begin
    region = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        region.hit   = 1'b1;
        region.ro    = RO[i];
        region.destr = DESTR[i];
        region.allow = MASKS[i*NMODES +: NMODES];
      end
    end
  end
endmodule

// File: rtl/acg_mode_check.sv
module acg_mode_check
  import acg_pkg::*;
#(
  parameter logic [NMODES-1:0] DATA_MODES = 8'h3B
) (
  input  acg_region_t       region,
  input  logic [MODE_W-1:0] mode,
  input  logic              rd,
  input  logic              sec,
  input  logic              log_en,
  input  logic              log_ack,
  output logic              bad
);
  logic exempt;
  logic ro_viol;
  logic mode_viol;

  // secondary-address and logical data-space cycles never flag
  assign exempt    = sec | (log_en & ~log_ack);
  assign ro_viol   = region.ro & ~rd & DATA_MODES[mode];
  assign mode_viol = ~region.allow[mode];

  always_comb begin
    if (exempt)           bad = 1'b0;
    else if (!region.hit) bad = 1'b1;
    else                  bad = ro_viol | mode_viol;
  end
endmodule

// File: rtl/acg_resp_latch.sv
module acg_resp_latch (
  input  logic clk,
  input  logic rst,
  input  logic stb1,
  input  logic bad_c,
  input  logic destr_c,
  input  logic rd_in,
  output logic bad_q,
  output logic rd_out
);
  logic destr_q;
  logic eff_bad;
  logic eff_destr;

  // transparent view while strobe 1 is high, held view after
  assign eff_bad   = stb1 ? bad_c   : bad_q;
  assign eff_destr = stb1 ? destr_c : destr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_q   <= 1'b0;
      destr_q <= 1'b0;
      rd_out  <= 1'b0;
    end else begin
      if (stb1) begin
        bad_q   <= bad_c;
        destr_q <= destr_c;
      end
      rd_out <= rd_in & ~(eff_bad & eff_destr);
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !stb1 |=> $stable(bad_q));

  assert_follow_R8: assert property (@(posedge clk) disable iff (rst)
    stb1 |=> (bad_q == $past(bad_c)));

  assert_strobe_src_R9: assert property (@(posedge clk) disable iff (rst)
    rd_out |-> $past(rd_in));
endmodule

// File: rtl/acg_decoder.sv
module acg_decoder
  import acg_pkg::*;
#(
  parameter int                     AW         = 8,
  parameter int                     NREG       = 4,
  parameter logic [NREG*AW-1:0]     BASE       = {8'h30, 8'h20, 8'h10, 8'h00},
  parameter logic [NREG*AW-1:0]     LAST       = {8'h3F, 8'h23, 8'h17, 8'h0F},
  parameter logic [NREG-1:0]        RO         = 4'b0110,
  parameter logic [NREG-1:0]        DESTR      = 4'b0100,
  parameter logic [NREG*NMODES-1:0] MASKS      = {8'hC7, 8'hFF, 8'hFF, 8'hFF},
  parameter logic [NMODES-1:0]      DATA_MODES = 8'h3B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb1_phase,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              op_read,
  input  logic [AW-1:0]     off_addr,
  input  logic              sec_cycle,
  input  logic              log_addr_en,
  input  logic              log_ack,
  input  logic              usr_rd_in,
  output logic              addr_bad,
  output logic              usr_rd_out
);
  acg_region_t region;
  logic        bad_c;

  acg_region_lookup #(
    .AW(AW), .NREG(NREG), .BASE(BASE), .LAST(LAST),
    .RO(RO), .DESTR(DESTR), .MASKS(MASKS)
  ) lookup_i (
    .addr   (off_addr),
    .region (region)
  );

  acg_mode_check #(.DATA_MODES(DATA_MODES)) check_i (
    .region  (region),
    .mode    (op_mode),
    .rd      (op_read),
    .sec     (sec_cycle),
    .log_en  (log_addr_en),
    .log_ack (log_ack),
    .bad     (bad_c)
  );

  acg_resp_latch latch_i (
    .clk     (clk),
    .rst     (rst),
    .stb1    (stb1_phase),
    .bad_c   (bad_c),
    .destr_c (region.destr),
    .rd_in   (usr_rd_in),
    .bad_q   (addr_bad),
    .rd_out  (usr_rd_out)
  );

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!addr_bad && !usr_rd_out));

  assert_exempt_R4: assert property (@(posedge clk) disable iff (rst)
    (stb1_phase && sec_cycle) |=> !addr_bad);

  assert_logical_R5: assert property (@(posedge clk) disable iff (rst)
    (stb1_phase && log_addr_en && !log_ack) |=> !addr_bad);

  assert_destr_block_R9: assert property (@(posedge clk) disable iff (rst)
    (stb1_phase && usr_rd_in && bad_c && region.destr) |=> !usr_rd_out);
endmodule

// File: tb/acg_decoder_tb.sv
module acg_decoder_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stb1_phase = 1'b0;
  logic [2:0] op_mode = '0;
  logic       op_read = 1'b0;
  logic [7:0] off_addr = '0;
  logic       sec_cycle = 1'b0;
  logic       log_addr_en = 1'b0;
  logic       log_ack = 1'b0;
  logic       usr_rd_in = 1'b0;
  logic       addr_bad;
  logic       usr_rd_out;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acg_decoder dut_i (
    .clk(clk), .rst(rst), .stb1_phase(stb1_phase), .op_mode(op_mode),
    .op_read(op_read), .off_addr(off_addr), .sec_cycle(sec_cycle),
    .log_addr_en(log_addr_en), .log_ack(log_ack), .usr_rd_in(usr_rd_in),
    .addr_bad(addr_bad), .usr_rd_out(usr_rd_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // reference decision from the requirements
  function automatic bit ref_bad(input logic [7:0] a, input logic [2:0] m,
                                 input bit rd, input bit sec, input bit le, input bit la);
    bit data_mode;
    data_mode = (m == 0) || (m == 1) || (m == 3) || (m == 4) || (m == 5);
    if (sec || (le && !la)) return 1'b0;
    if (a <= 8'h0F) return 1'b0;
    if (a >= 8'h10 && a <= 8'h23 && !(a >= 8'h18 && a <= 8'h1F))
      return !rd && data_mode;
    if (a >= 8'h30 && a <= 8'h3F) return (m >= 3 && m <= 5);
    return 1'b1;
  endfunction

  // present one operation during strobe 1, sample one clock later
  task automatic run_op(input string req, input logic [7:0] a, input logic [2:0] m,
                        input bit rd, input bit sec, input bit le, input bit la);
    @(negedge clk);
    stb1_phase = 1'b1; off_addr = a; op_mode = m; op_read = rd;
    sec_cycle = sec; log_addr_en = le; log_ack = la;
    @(negedge clk);
    stb1_phase = 1'b0;
    check(req, addr_bad, ref_bad(a, m, rd, sec, le, la));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 addr_bad", addr_bad, 1'b0);
    check("R1 usr_rd_out", usr_rd_out, 1'b0);
  endtask

  task automatic t_rw_region;
    for (int m = 0; m < 8; m++) begin
      run_op("R7 rw write", 8'h05, 3'(m), 1'b0, 1'b0, 1'b0, 1'b0);
      run_op("R7 rw read", 8'h0F, 3'(m), 1'b1, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_read_only;
    for (int m = 0; m < 8; m++) begin
      if (m == 2 || m == 6 || m == 7)
        run_op("R3 ro write exempt mode", 8'h12, 3'(m), 1'b0, 1'b0, 1'b0, 1'b0);
      else
        run_op("R2 ro write data mode", 8'h12, 3'(m), 1'b0, 1'b0, 1'b0, 1'b0);
      run_op("R2 ro read", 8'h17, 3'(m), 1'b1, 1'b0, 1'b0, 1'b0);
      run_op("R2 fifo write", 8'h20, 3'(m), 1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_mode_mask;
    for (int m = 0; m < 8; m++) begin
      run_op("R6 mask read", 8'h33, 3'(m), 1'b1, 1'b0, 1'b0, 1'b0);
      run_op("R6 mask write", 8'h3F, 3'(m), 1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_unmapped_sec;
    for (int m = 0; m < 8; m++) begin
      run_op("R7 unmapped", 8'h50, 3'(m), 1'b1, 1'b0, 1'b0, 1'b0);
      run_op("R7 gap", 8'h1A, 3'(m), 1'b0, 1'b0, 1'b0, 1'b0);
      run_op("R4 sec unmapped", 8'h50, 3'(m), 1'b0, 1'b1, 1'b0, 1'b0);
      run_op("R4 sec ro", 8'h12, 3'(m), 1'b0, 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_logical;
    run_op("R5 en noack", 8'h12, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op("R5 en ack", 8'h12, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_op("R5 dis noack", 8'h12, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op("R5 en noack unmapped", 8'hA0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0);
    run_op("R5 dis ack unmapped", 8'hA0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_hold;
    run_op("R8 capture bad", 8'h50, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    off_addr = 8'h05; sec_cycle = 1'b1;
    @(negedge clk);
    check("R8 hold bad", addr_bad, 1'b1);
    @(negedge clk);
    check("R8 hold bad 2", addr_bad, 1'b1);
    sec_cycle = 1'b0;
    run_op("R8 capture ok", 8'h05, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    off_addr = 8'h50;
    @(negedge clk);
    check("R8 hold ok", addr_bad, 1'b0);
  endtask

  task automatic t_strobe;
    @(negedge clk);
    stb1_phase = 1'b1; off_addr = 8'h21; op_mode = 3'd0; op_read = 1'b1;
    sec_cycle = 1'b0; log_addr_en = 1'b0; usr_rd_in = 1'b1;
    @(negedge clk);
    check("R9 fifo ok read passes", usr_rd_out, 1'b1);
    op_read = 1'b0;
    @(negedge clk);
    check("R9 fifo bad suppressed", usr_rd_out, 1'b0);
    check("R9 fifo bad flag", addr_bad, 1'b1);
    off_addr = 8'h12;
    @(negedge clk);
    check("R9 ro bad not suppressed", usr_rd_out, 1'b1);
    check("R9 ro bad flag", addr_bad, 1'b1);
    usr_rd_in = 1'b0;
    @(negedge clk);
    check("R9 delayed release", usr_rd_out, 1'b0);
    off_addr = 8'h22;
    @(negedge clk);
    stb1_phase = 1'b0; off_addr = 8'h05; op_read = 1'b1; usr_rd_in = 1'b1;
    @(negedge clk);
    check("R9 held destr bad suppressed", usr_rd_out, 1'b0);
    usr_rd_in = 1'b0;
    @(negedge clk);
    check("R9 idle low", usr_rd_out, 1'b0);
  endtask

  initial begin
    t_reset();
    t_rw_region();
    t_read_only();
    t_mode_mask();
    t_unmapped_sec();
    t_logical();
    t_hold();
    t_strobe();
    t_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule